// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

This block sits in front of a two-channel memory controller in which each 64-bit channel carries at most one DIMM. Every valid request carries a flat system physical address. The block translates it into a channel select and a channel-local byte address. It also flags addresses that fall beyond the installed memory. The per-channel capacities come from configuration inputs, and a mode input chooses how the two channels are combined.

Three organisations are supported.

- **Interleaved.** Consecutive 64-byte lines alternate between the channels. This mode assumes that both channels hold the same amount of memory.
- **Stacked.** Channel A fills the low part of the address space and channel B sits directly above it. This mode suits a populated pair of unequal size.
- **Flexible.** The region from zero up to twice the smaller capacity is interleaved. The rest of the larger channel is mapped linearly above that region.

The translation is registered, so each result appears one clock after its request. Capacities are byte counts, each a multiple of 128. Configuration may change only while no request is in flight.

Top module: `dchan_addr_mapper`

## Requirements
- R1: While reset is held, and after it is released until the first request, `rsp_valid`, `rsp_ch_sel`, `rsp_ch_addr` and `rsp_oor` are all zero.
- R2: `rsp_valid` is high in exactly those cycles that follow a cycle with `req_valid` high. Back-to-back requests give back-to-back results in request order.
- R3: In interleaved mode (`cfg_mode` = 0), an address below 2*min(capA,capB) maps as follows. Address bit 6 picks the channel: 0 gives channel A (`rsp_ch_sel` = 2'b01) and 1 gives channel B (`rsp_ch_sel` = 2'b10). The channel address is the request address with bit 6 removed: bits above 6 shift down one place and bits 5:0 are kept.
- R4: In interleaved mode, an address at or above 2*min(capA,capB) is out of range, even when the total capacity is larger.
- R5: In stacked mode (`cfg_mode` = 1), an address below capA goes to channel A with the channel address equal to the request address.
- R6: In stacked mode, an address from capA up to capA+capB-1 goes to channel B with the channel address equal to the request address minus capA.
- R7: In flexible mode (`cfg_mode` = 2), an address below 2*min(capA,capB) is interleaved exactly as in R3.
- R8: In flexible mode, an address from 2*min(capA,capB) up to capA+capB-1 goes to the channel with the larger capacity. Its channel address is the request address minus min(capA,capB).
- R9: In any mode, an address at or above capA+capB gives `rsp_oor` = 1, `rsp_ch_sel` = 2'b00 and `rsp_ch_addr` = 0. A valid result that is in range has exactly one select bit set.
- R10: `cfg_mode` = 3 behaves exactly like stacked mode.
- R11: In flexible mode with one channel empty, every in-range address goes linearly to the populated channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Organisation: 0 interleaved, 1 stacked, 2 flexible, 3 stacked |
| cfg_cap_a | input | 34 | Channel A capacity in bytes |
| cfg_cap_b | input | 34 | Channel B capacity in bytes |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 34 | System physical byte address |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_ch_sel | output | 2 | One-hot channel select, bit 0 = A, bit 1 = B; zero when out of range |
| rsp_ch_addr | output | 34 | Channel-local byte address |
| rsp_oor | output | 1 | Address lies beyond the installed memory |

## Verification
A wrong boundary, such as the interleave top, the stacked split or the total, shows up on the very next `rsp_valid` cycle. An address placed on one side of the boundary then produces the wrong select or a false out-of-range flag. The bench therefore probes each boundary at the address just below it and the address exactly on it. A lost or swapped bit in the interleave squeeze, or a wrong subtraction offset, corrupts `rsp_ch_addr` in that same cycle. Addresses with mixed bits above and below bit 6 expose such faults. A select that is not one-hot, or that is set together with the out-of-range flag, is caught by the assertions on the first result that carries it.

// File: rtl/dchan_map_pkg.sv
package dchan_map_pkg;

    // System address width (bytes) and the address bit that alternates channels.
    parameter int MAP_ADDR_W  = 34;
    parameter int MAP_ILV_BIT = 6;

    localparam int MAP_SUM_W  = MAP_ADDR_W + 1;

    typedef logic [MAP_ADDR_W-1:0] sys_addr_t;
    typedef logic [MAP_SUM_W-1:0]  sum_t;

    typedef enum logic [1:0] {
        MAP_ILV   = 2'd0,
        MAP_STACK = 2'd1,
        MAP_FLEX  = 2'd2,
        MAP_ALT   = 2'd3
    } map_mode_e;

    typedef enum logic [2:0] {
        ZONE_ILV,
        ZONE_LOW_A,
        ZONE_HIGH_B,
        ZONE_REMAIN,
        ZONE_NONE
    } map_zone_e;

    // Boundaries derived once from the capacity registers.
    typedef struct packed {
        sum_t      ilv_top;
        sum_t      total;
        sum_t      cap_a;
        sys_addr_t min_cap;
        logic      big_is_b;
    } zone_cfg_t;

    typedef struct packed {
        logic [1:0] sel;
        sys_addr_t  ch_addr;
        logic       oor;
    } map_res_t;

    // Remove the interleave bit: upper bits slide down, line offset is kept.
    function automatic sys_addr_t squeeze_ilv(input sys_addr_t a);
        return {1'b0, a[MAP_ADDR_W-1:MAP_ILV_BIT+1], a[MAP_ILV_BIT-1:0]};
    endfunction

endpackage

// File: rtl/map_zone_cfg.sv
module map_zone_cfg
    import dchan_map_pkg::*;
(
    input  sys_addr_t cap_a,
    input  sys_addr_t cap_b,
    output zone_cfg_t zcfg
);
    sys_addr_t min_c;

    always_comb begin
        min_c          = (cap_a < cap_b) ? cap_a : cap_b;
        zcfg.min_cap   = min_c;
        zcfg.ilv_top   = {min_c, 1'b0};
        zcfg.total     = {1'b0, cap_a} + {1'b0, cap_b};
        zcfg.cap_a     = {1'b0, cap_a};
        zcfg.big_is_b  = (cap_b > cap_a);
    end
endmodule

// File: rtl/map_zone_sel.sv
module map_zone_sel
    import dchan_map_pkg::*;
(
    input  map_mode_e mode,
    input  sys_addr_t addr,
    input  sum_t      ilv_top,
    input  sum_t      total,
    input  sum_t      cap_a,
    output map_zone_e zone
);
    sum_t ext;

    always_comb begin
        ext  = {1'b0, addr};
        zone = ZONE_NONE;
        unique case (mode)
            MAP_ILV: begin
                if (ext < ilv_top) zone = ZONE_ILV;
            end
            MAP_FLEX: begin
                if (ext < ilv_top)    zone = ZONE_ILV;
                else if (ext < total) zone = ZONE_REMAIN;
            end
            MAP_STACK, MAP_ALT: begin
                if (ext < cap_a)      zone = ZONE_LOW_A;
                else if (ext < total) zone = ZONE_HIGH_B;
            end
            default: zone = ZONE_NONE;
        endcase
    end
endmodule

// File: rtl/map_xlate.sv
module map_xlate
    import dchan_map_pkg::*;
(
    input  map_zone_e zone,
    input  sys_addr_t addr,
    input  sum_t      cap_a,
    input  sys_addr_t min_cap,
    input  logic      big_is_b,
    output map_res_t  res
);
    sys_addr_t cap_a_n;

    always_comb begin
        cap_a_n     = cap_a[MAP_ADDR_W-1:0];
        res.sel     = 2'b00;
        res.ch_addr = '0;
        res.oor     = 1'b0;
        unique case (zone)
            ZONE_ILV: begin
                res.sel     = addr[MAP_ILV_BIT] ? 2'b10 : 2'b01;
                res.ch_addr = squeeze_ilv(addr);
            end
            ZONE_LOW_A: begin
                res.sel     = 2'b01;
                res.ch_addr = addr;
            end
            ZONE_HIGH_B: begin
                res.sel     = 2'b10;
                res.ch_addr = addr - cap_a_n;
            end
            ZONE_REMAIN: begin
                res.sel     = big_is_b ? 2'b10 : 2'b01;
                res.ch_addr = addr - min_cap;
            end
            default: begin
                res.oor     = 1'b1;
            end
        endcase
    end

    // cap_a carries a spare top bit for comparisons; it is always zero here.
    logic unused_top;
    assign unused_top = cap_a[MAP_SUM_W-1];
endmodule

// File: rtl/dchan_addr_mapper.sv
module dchan_addr_mapper
    import dchan_map_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            cfg_mode,
    input  logic [MAP_ADDR_W-1:0] cfg_cap_a,
    input  logic [MAP_ADDR_W-1:0] cfg_cap_b,
    input  logic                  req_valid,
    input  logic [MAP_ADDR_W-1:0] req_addr,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_ch_sel,
    output logic [MAP_ADDR_W-1:0] rsp_ch_addr,
    output logic                  rsp_oor
);
    zone_cfg_t zcfg;
    map_zone_e zone;
    map_res_t  res_d;
    map_res_t  res_q;
    logic      vld_q;

    map_zone_cfg u_cfg (
        .cap_a (cfg_cap_a),
        .cap_b (cfg_cap_b),
        .zcfg  (zcfg)
    );

    map_zone_sel u_sel (
        .mode    (map_mode_e'(cfg_mode)),
        .addr    (req_addr),
        .ilv_top (zcfg.ilv_top),
        .total   (zcfg.total),
        .cap_a   (zcfg.cap_a),
        .zone    (zone)
    );

    map_xlate u_xl (
        .zone     (zone),
        .addr     (req_addr),
        .cap_a    (zcfg.cap_a),
        .min_cap  (zcfg.min_cap),
        .big_is_b (zcfg.big_is_b),
        .res      (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) res_q <= res_d;
        end
    end

    assign rsp_valid   = vld_q;
    assign rsp_ch_sel  = res_q.sel;
    assign rsp_ch_addr = res_q.ch_addr;
    assign rsp_oor     = res_q.oor;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                              // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);                                            // R2
    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot0(rsp_ch_sel));                                   // R9
    AST_OOR_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_oor) |-> (rsp_ch_sel == 2'b00 && rsp_ch_addr == '0)); // R9
    AST_INRANGE_HAS_SEL: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_oor) |-> ($countones(rsp_ch_sel) == 1));           // R9
    AST_A_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ch_sel[0]) |-> (rsp_ch_addr < $past(cfg_cap_a)));    // R5
    AST_B_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ch_sel[1]) |-> (rsp_ch_addr < $past(cfg_cap_b)));    // R6
endmodule

// File: tb/test_dchan_addr_mapper.sv
module test_dchan_addr_mapper;
    localparam int AW  = 34;
    localparam int IB  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_mode = 2'd0;
    logic [AW-1:0] cfg_cap_a = '0;
    logic [AW-1:0] cfg_cap_b = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_ch_sel;
    logic [AW-1:0] rsp_ch_addr;
    logic          rsp_oor;

    always #2 clk = ~clk;

    dchan_addr_mapper i_dchan_addr_mapper (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
        .cfg_cap_a(cfg_cap_a), .cfg_cap_b(cfg_cap_b),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ch_sel(rsp_ch_sel),
        .rsp_ch_addr(rsp_ch_addr), .rsp_oor(rsp_oor)
    );

    typedef struct {
        logic [1:0] sel;
        longint     addr;
        bit         oor;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    longint cap_a_m = 0;
    longint cap_b_m = 0;

    function automatic exp_t model(input int mode, input longint a, input string tag);
        exp_t e;
        longint mn, tot, sq;
        mn  = (cap_a_m < cap_b_m) ? cap_a_m : cap_b_m;
        tot = cap_a_m + cap_b_m;
        sq  = ((a >> (IB + 1)) << IB) | (a & ((64'd1 << IB) - 1));
        e.sel = 2'b00; e.addr = 0; e.oor = 1'b0; e.tag = tag;
        if (mode == 0) begin
            if (a < 2 * mn) begin e.sel = a[IB] ? 2'b10 : 2'b01; e.addr = sq; end
            else e.oor = 1'b1;
        end else if (mode == 2) begin
            if (a < 2 * mn) begin e.sel = a[IB] ? 2'b10 : 2'b01; e.addr = sq; end
            else if (a < tot) begin e.sel = (cap_b_m > cap_a_m) ? 2'b10 : 2'b01; e.addr = a - mn; end
            else e.oor = 1'b1;
        end else begin
            if (a < cap_a_m) begin e.sel = 2'b01; e.addr = a; end
            else if (a < tot) begin e.sel = 2'b10; e.addr = a - cap_a_m; end
            else e.oor = 1'b1;
        end
        return e;
    endfunction

    task automatic send(input int mode, input longint a, input string tag);
        @(negedge clk);
        cfg_mode  = mode[1:0];
        req_addr  = a[AW-1:0];
        req_valid = 1'b1;
        exp_q.push_back(model(mode, a, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic set_caps(input longint ca, input longint cb);
        idle(3);
        cap_a_m = ca; cap_b_m = cb;
        cfg_cap_a = ca[AW-1:0];
        cfg_cap_b = cb[AW-1:0];
        idle(1);
    endtask

    // Monitor: pops the scoreboard as results appear, and checks the strobe timing (R2).
    always @(posedge clk) begin
        bit sent;
        sent = req_valid && !rst;
        #1;
        if (!rst && !done) begin
            checks++;
            if (rsp_valid !== sent) begin
                errors++;
                $display("FAIL R2 rsp_valid actual %0b expected %0b", rsp_valid, sent);
            end
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected result actual sel %b expected none", rsp_ch_sel);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (rsp_ch_sel !== e.sel || rsp_oor !== e.oor || rsp_ch_addr !== e.addr[AW-1:0]) begin
                        errors++;
                        $display("FAIL %s actual sel=%b addr=%h oor=%b expected sel=%b addr=%h oor=%b",
                                 e.tag, rsp_ch_sel, rsp_ch_addr, rsp_oor, e.sel, e.addr[AW-1:0], e.oor);
                    end
                end
            end
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog actual timeout expected completion");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 during reset
        if (rsp_valid !== 1'b0 || rsp_ch_sel !== 2'b00 || rsp_oor !== 1'b0 || rsp_ch_addr !== '0) begin
            errors++;
            $display("FAIL R1 actual v=%b sel=%b oor=%b expected zeros", rsp_valid, rsp_ch_sel, rsp_oor);
        end
        rst = 1'b0;
        set_caps(64'h4000, 64'h2000);
        checks++;   // R1 after release, before any request
        if (rsp_valid !== 1'b0 || rsp_ch_sel !== 2'b00 || rsp_ch_addr !== '0) begin
            errors++;
            $display("FAIL R1 actual v=%b sel=%b expected zeros", rsp_valid, rsp_ch_sel);
        end

        // Flexible: A larger
        send(2, 64'h0000, "R7");
        send(2, 64'h0040, "R7");
        send(2, 64'h00C5, "R7");
        send(2, 64'h3FFF, "R7");
        send(2, 64'h4000, "R8");
        send(2, 64'h5FFF, "R8");
        send(2, 64'h6000, "R9");
        send(2, 64'h3_0000_0000, "R9");
        idle(2);
        // Stacked and the alias mode
        send(1, 64'h3FFF, "R5");
        send(1, 64'h1234, "R5");
        send(1, 64'h4000, "R6");
        send(1, 64'h5FFF, "R6");
        send(1, 64'h6000, "R9");
        send(3, 64'h3FC0, "R10");
        send(3, 64'h4ABC, "R10");
        idle(1);
        // Interleaved with unequal capacities
        send(0, 64'h3FFF, "R3");
        send(0, 64'h4000, "R4");
        send(0, 64'h5000, "R4");
        // Flexible: B larger
        set_caps(64'h1000, 64'h8000);
        send(2, 64'h1FFF, "R7");
        send(2, 64'h2000, "R8");
        send(2, 64'h8FFF, "R8");
        send(2, 64'h9000, "R9");
        // Interleaved with equal capacities
        set_caps(64'h4000, 64'h4000);
        send(0, 64'h0000, "R3");
        send(0, 64'h0041, "R3");
        send(0, 64'h1ABF, "R3");
        send(0, 64'h7FFF, "R3");
        send(0, 64'h8000, "R9");
        // Flexible with one channel empty
        set_caps(64'h2000, 64'h0000);
        send(2, 64'h0100, "R11");
        send(2, 64'h1FFF, "R11");
        send(2, 64'h2000, "R11");
        set_caps(64'h0000, 64'h2000);
        send(2, 64'h0040, "R11");
        send(2, 64'h1FFF, "R11");
        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 pending results actual %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule